// File: doc/BRIEF.md
# Two-Slot Command Queue with Bypass Opcodes

The block sits between a host register port and a protocol execution sequencer. The host writes 8-bit command words. Bit 7 of a word is a DMA flag and bits 6:0 carry the opcode. Ordinary commands land in a two-slot queue. The bottom slot is the command the sequencer is working on. The top slot waits behind it. When the sequencer reports completion, the waiting command drops into the bottom slot and is handed out with a one-cycle issue strobe.

A small parameterised set of urgent opcodes never enters the queue. These are bus reset, device reset and DMA stop, whose opcodes are 0x03, 0x02 and 0x04. They leave on their own strobe the cycle after they are written, whatever the queue holds.

A flush input abandons the active command and any waiting one. It tells the sequencer through an abort strobe. It keeps the read-back word, which always shows the most recently started command. A write that finds both slots occupied is lost and raises a sticky error flag.

Top module: `cmd_queue`

## Requirements
- R1: During and right after reset, q_busy, seq_issue, urg_issue, seq_abort and ovf_err are 0 and cmd_rdback is 0x00.
- R2: A non-urgent write into an empty queue, with no flush, gives seq_issue high for exactly the next cycle. In that cycle seq_cmd equals the written word and seq_dma equals its bit 7.
- R3: A non-urgent write while one command is active is held without an issue strobe. On seq_done the held word becomes seq_cmd, with seq_issue high in the following cycle. If seq_done and a write arrive together while only one command is held, the written word is issued next.
- R4: A non-urgent write while both slots are occupied and seq_done is low is discarded, and it sets ovf_err. ovf_err then stays high until a flush.
- R5: A write whose bits 6:0 equal 0x02, 0x03 or 0x04 is urgent, whatever the value of bit 7. It is never stored and never raises ovf_err. It gives urg_issue high in the next cycle with urg_cmd equal to the word, even when flush is asserted in the same cycle.
- R6: cmd_rdback shows the most recently started command, ordinary or urgent, and keeps it after the queue drains. If an urgent write and a queue advance happen in the same cycle, the urgent word is shown.
- R7: A flush empties the queue for the next cycle. It pulses seq_abort for one cycle only if the queue held a command. It clears ovf_err and discards a non-urgent write made in the same cycle. It leaves cmd_rdback unchanged unless an urgent word is written in that cycle.
- R8: seq_done while the queue is empty has no effect: no issue strobe follows and q_busy stays low.
- R9: With both slots occupied, a write made in the same cycle as seq_done fills the freed slot without raising ovf_err. It is issued after the next completion.
- R10: The completion of the last held command drops q_busy in the next cycle, and seq_issue stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host command write strobe |
| host_cmd | input | 8 | Command word: bit 7 DMA flag, bits 6:0 opcode |
| flush | input | 1 | Abandon active and waiting commands |
| seq_done | input | 1 | One-cycle completion pulse from the sequencer |
| seq_issue | output | 1 | One-cycle strobe: seq_cmd has just become active |
| seq_cmd | output | 8 | Active (bottom-slot) command |
| seq_dma | output | 1 | DMA flag of the active command |
| seq_abort | output | 1 | One-cycle strobe: active command abandoned by flush |
| urg_issue | output | 1 | One-cycle strobe for an urgent command |
| urg_cmd | output | 8 | Last urgent command word |
| cmd_rdback | output | 8 | Most recently started command |
| q_busy | output | 1 | At least one command held |
| ovf_err | output | 1 | Sticky write-while-full error |

## Verification
The bench builds the block with its default parameters: two slots, 8-bit words, and the three urgent opcodes 0x02, 0x03 and 0x04. With only two slots, the full state is reached after two writes. This puts the overflow drop, the same-cycle write-and-completion refill and urgent bypass under a full queue all within a few cycles of directed stimulus. The same settings also let the bench show directly at the ports that a flush discards both slots and that the read-back word survives it.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int unsigned CMD_W = 8;
  localparam int unsigned OPC_W = CMD_W - 1;

  typedef logic [CMD_W-1:0] cmd_t;
  typedef logic [OPC_W-1:0] opc_t;

  function automatic logic dma_flag(cmd_t c);
    return c[CMD_W-1];
  endfunction

  function automatic opc_t opcode_of(cmd_t c);
    return c[OPC_W-1:0];
  endfunction
endpackage

// File: rtl/cmdq_imm_dec.sv
module cmdq_imm_dec
  import cmdq_pkg::*;
#(
  parameter int unsigned NUM_IMM = 3,
  parameter logic [NUM_IMM*OPC_W-1:0] IMM_LIST = {7'h04, 7'h03, 7'h02}
) (
  input  cmd_t cmd,
  output logic hit
);
  logic [NUM_IMM-1:0] match;

  for (genvar gi = 0; gi < NUM_IMM; gi++) begin : g_cmp
    assign match[gi] = (opcode_of(cmd) == IMM_LIST[gi*OPC_W +: OPC_W]);
  end

  assign hit = |match;
endmodule

// File: rtl/cmdq_store.sv
module cmdq_store
  import cmdq_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop_req,
  input  logic             flush,
  input  cmd_t             din,
  output cmd_t             bottom,
  output cmd_t             bottom_next,
  output logic [CNT_W-1:0] count,
  output logic             fresh,
  output logic             overflow
);
  cmd_t             slot_q [DEPTH];
  cmd_t             slot_d [DEPTH];
  cmd_t             shift_src [DEPTH];
  logic [DEPTH-1:0] slot_en;
  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic             pop, room, take;

  assign pop = pop_req && (cnt_q != '0);

  always_comb begin
    base     = pop ? cnt_q - 1'b1 : cnt_q;
    room     = (base < CNT_W'(DEPTH));
    take     = push && !flush && room;
    overflow = push && !flush && !room;
    cnt_d    = flush ? '0 : base + CNT_W'(take);
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) shift_src[i] = slot_q[i];
    for (int i = 1; i < DEPTH; i++) shift_src[i-1] = slot_q[i];
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      slot_d[i]  = slot_q[i];
      slot_en[i] = 1'b0;
      if (!flush) begin
        if (take && base == CNT_W'(i)) begin
          slot_d[i]  = din;
          slot_en[i] = 1'b1;
        end else if (pop) begin
          slot_d[i]  = shift_src[i];
          slot_en[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_en[i]) slot_q[i] <= slot_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fresh       = !flush && (cnt_d != '0) && (pop || cnt_q == '0);
  assign bottom      = slot_q[0];
  assign bottom_next = slot_d[0];
  assign count       = cnt_q;

  // R4: a dropped write leaves the occupancy untouched
  assert_drop_keeps_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> cnt_q == $past(cnt_q));

  // R8: completion on an empty queue changes nothing
  assert_idle_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cnt_q == '0 && !push) |=> cnt_q == '0);
endmodule

// File: rtl/cmdq_issue.sv
module cmdq_issue
  import cmdq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fresh,
  input  cmd_t bottom_next,
  input  logic imm_we,
  input  cmd_t host_cmd,
  input  logic flush,
  input  logic busy_now,
  input  logic overflow,
  output logic seq_issue,
  output logic urg_issue,
  output cmd_t urg_cmd,
  output cmd_t rdback,
  output logic abort,
  output logic err
);
  logic issue_d, urg_d, abort_d, err_d, urg_en, rd_en;
  cmd_t rd_d;

  always_comb begin
    issue_d = fresh;
    urg_d   = imm_we;
    urg_en  = imm_we;
    abort_d = flush && busy_now;
    err_d   = flush ? 1'b0 : (err || overflow);
    rd_en   = imm_we || fresh;
    rd_d    = imm_we ? host_cmd : bottom_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_issue <= 1'b0;
      urg_issue <= 1'b0;
      abort     <= 1'b0;
      err       <= 1'b0;
    end else begin
      seq_issue <= issue_d;
      urg_issue <= urg_d;
      abort     <= abort_d;
      err       <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      urg_cmd <= '0;
    else if (urg_en) urg_cmd <= host_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdback <= '0;
    else if (rd_en) rdback <= rd_d;
  end

  // R4: the error flag only rises after a write hit a full queue
  assert_err_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(overflow));

  // R7: abort strobe lasts a single cycle
  assert_abort_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !(flush && busy_now)) |=> !abort);
endmodule

// File: rtl/cmd_queue.sv
module cmd_queue
  import cmdq_pkg::*;
#(
  parameter int unsigned DEPTH   = 2,
  parameter int unsigned NUM_IMM = 3,
  parameter logic [NUM_IMM*OPC_W-1:0] IMM_LIST = {7'h04, 7'h03, 7'h02},
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [CMD_W-1:0] host_cmd,
  input  logic             flush,
  input  logic             seq_done,
  output logic             seq_issue,
  output logic [CMD_W-1:0] seq_cmd,
  output logic             seq_dma,
  output logic             seq_abort,
  output logic             urg_issue,
  output logic [CMD_W-1:0] urg_cmd,
  output logic [CMD_W-1:0] cmd_rdback,
  output logic             q_busy,
  output logic             ovf_err
);
  logic             imm_hit, imm_we, push, fresh, overflow;
  cmd_t             bottom, bottom_next;
  logic [CNT_W-1:0] count;

  cmdq_imm_dec #(.NUM_IMM(NUM_IMM), .IMM_LIST(IMM_LIST)) u_dec (
    .cmd (host_cmd),
    .hit (imm_hit)
  );

  assign imm_we = host_we && imm_hit;
  assign push   = host_we && !imm_hit;

  cmdq_store #(.DEPTH(DEPTH)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push),
    .pop_req     (seq_done),
    .flush       (flush),
    .din         (host_cmd),
    .bottom      (bottom),
    .bottom_next (bottom_next),
    .count       (count),
    .fresh       (fresh),
    .overflow    (overflow)
  );

  cmdq_issue u_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .fresh       (fresh),
    .bottom_next (bottom_next),
    .imm_we      (imm_we),
    .host_cmd    (host_cmd),
    .flush       (flush),
    .busy_now    (count != '0),
    .overflow    (overflow),
    .seq_issue   (seq_issue),
    .urg_issue   (urg_issue),
    .urg_cmd     (urg_cmd),
    .rdback      (cmd_rdback),
    .abort       (seq_abort),
    .err         (ovf_err)
  );

  assign seq_cmd = bottom;
  assign seq_dma = dma_flag(bottom);
  assign q_busy  = (count != '0);

  // R2: write into an empty queue starts on the next cycle
  assert_start_from_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush && !q_busy) |=> seq_issue && seq_cmd == $past(host_cmd));

  // R3: an issue strobe always names a held command
  assert_issue_needs_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_issue |-> q_busy);

  // R5: urgent words bypass the queue
  assert_urgent_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    imm_we |=> urg_issue && urg_cmd == $past(host_cmd));

  // R7: flush empties the queue and keeps the read-back word
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !imm_we) |=> !q_busy && cmd_rdback == $past(cmd_rdback));

  // R10: last completion drains the queue
  assert_last_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && count == CNT_W'(1) && !host_we && !flush) |=> !q_busy && !seq_issue);
endmodule

// File: tb/cmd_queue_test.sv
`timescale 1ns/1ps
module cmd_queue_test;
  logic       clk = 1'b0;
  logic       rst_n, host_we, flush, seq_done;
  logic [7:0] host_cmd;
  logic       seq_issue, seq_dma, seq_abort, urg_issue, q_busy, ovf_err;
  logic [7:0] seq_cmd, urg_cmd, cmd_rdback;
  int         n_tests = 0;
  int         n_fail  = 0;

  always #10 clk = ~clk;

  cmd_queue uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_cmd(host_cmd),
    .flush(flush), .seq_done(seq_done), .seq_issue(seq_issue),
    .seq_cmd(seq_cmd), .seq_dma(seq_dma), .seq_abort(seq_abort),
    .urg_issue(urg_issue), .urg_cmd(urg_cmd), .cmd_rdback(cmd_rdback),
    .q_busy(q_busy), .ovf_err(ovf_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] c, input logic d, input logic f);
    host_we = 1'b1; host_cmd = c; seq_done = d; flush = f;
    @(negedge clk);
    host_we = 1'b0; seq_done = 1'b0; flush = 1'b0;
  endtask

  task automatic done_pulse();
    seq_done = 1'b1;
    @(negedge clk);
    seq_done = 1'b0;
  endtask

  task automatic flush_pulse();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 q_busy", q_busy, 0);
    chk("R1 seq_issue", seq_issue, 0);
    chk("R1 urg_issue", urg_issue, 0);
    chk("R1 seq_abort", seq_abort, 0);
    chk("R1 ovf_err", ovf_err, 0);
    chk("R1 cmd_rdback", cmd_rdback, 8'h00);
  endtask

  task automatic t_queue();
    put(8'h91, 0, 0);
    chk("R2 seq_issue", seq_issue, 1);
    chk("R2 seq_cmd", seq_cmd, 8'h91);
    chk("R2 seq_dma", seq_dma, 1);
    chk("R6 rdback first", cmd_rdback, 8'h91);
    put(8'h12, 0, 0);
    chk("R2 single strobe", seq_issue, 0);
    chk("R3 held not issued", seq_cmd, 8'h91);
    done_pulse();
    chk("R3 advance strobe", seq_issue, 1);
    chk("R3 advance cmd", seq_cmd, 8'h12);
    chk("R3 dma flag clear", seq_dma, 0);
    done_pulse();
    chk("R10 drained", q_busy, 0);
    chk("R10 no strobe", seq_issue, 0);
    chk("R6 rdback kept", cmd_rdback, 8'h12);
  endtask

  task automatic t_idle_done();
    done_pulse();
    chk("R8 no strobe", seq_issue, 0);
    chk("R8 still empty", q_busy, 0);
  endtask

  task automatic t_overflow();
    put(8'h21, 0, 0);
    put(8'h22, 0, 0);
    put(8'h23, 0, 0);
    chk("R4 error set", ovf_err, 1);
    chk("R4 active kept", seq_cmd, 8'h21);
    done_pulse();
    chk("R4 second kept", seq_cmd, 8'h22);
    chk("R4 error sticky", ovf_err, 1);
    done_pulse();
    chk("R4 third dropped", q_busy, 0);
    flush_pulse();
    chk("R7 error cleared", ovf_err, 0);
    chk("R7 no abort when empty", seq_abort, 0);
  endtask

  task automatic t_urgent();
    put(8'h31, 0, 0);
    put(8'h32, 0, 0);
    put(8'h83, 0, 0);
    chk("R5 urgent strobe", urg_issue, 1);
    chk("R5 urgent word", urg_cmd, 8'h83);
    chk("R5 no error when full", ovf_err, 0);
    chk("R5 queue untouched", seq_cmd, 8'h31);
    chk("R6 urgent shown", cmd_rdback, 8'h83);
    @(negedge clk);
    chk("R5 urgent single", urg_issue, 0);
    done_pulse();
    chk("R5 not stored", seq_cmd, 8'h32);
    chk("R6 advance shown", cmd_rdback, 8'h32);
    put(8'h04, 0, 1);
    chk("R5 urgent with flush", urg_issue, 1);
    chk("R5 urgent word flush", urg_cmd, 8'h04);
    chk("R7 abort", seq_abort, 1);
    chk("R7 emptied", q_busy, 0);
  endtask

  task automatic t_flush();
    put(8'h41, 0, 0);
    put(8'h42, 0, 0);
    put(8'h44, 0, 1);
    chk("R7 abort strobe", seq_abort, 1);
    chk("R7 emptied", q_busy, 0);
    chk("R7 rdback kept", cmd_rdback, 8'h41);
    @(negedge clk);
    chk("R7 abort single", seq_abort, 0);
    chk("R7 write discarded", q_busy, 0);
    put(8'h45, 0, 0);
    chk("R7 restart cmd", seq_cmd, 8'h45);
    done_pulse();
    chk("R7 pending dropped", q_busy, 0);
  endtask

  task automatic t_refill();
    put(8'h51, 0, 0);
    put(8'h52, 0, 0);
    put(8'h53, 1, 0);
    chk("R9 advance strobe", seq_issue, 1);
    chk("R9 advance cmd", seq_cmd, 8'h52);
    chk("R9 no error", ovf_err, 0);
    done_pulse();
    chk("R9 refill issued", seq_cmd, 8'h53);
    done_pulse();
    chk("R10 drained", q_busy, 0);
    put(8'h61, 0, 0);
    put(8'h62, 1, 0);
    chk("R3 swap strobe", seq_issue, 1);
    chk("R3 swap cmd", seq_cmd, 8'h62);
    done_pulse();
    chk("R10 drained again", q_busy, 0);
    chk("R6 last kept", cmd_rdback, 8'h62);
  endtask

  initial begin
    rst_n = 1'b0; host_we = 1'b0; host_cmd = '0; flush = 1'b0; seq_done = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_queue();
        t_idle_done();
        t_overflow();
        t_urgent();
        t_flush();
        t_refill();
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule